// File: doc/BRIEF.md
# Special-Purpose Register Access Unit

This block is the special-register file of a small RISC core. It serves the core's move-to-special-register and move-from-special-register instructions. The core presents a 16-bit register number, write data and strobes, and gets the read value back in the same cycle. The register number is split into a 5-bit group (bits 15:11) and an 11-bit index (bits 10:0). Group 0 holds system state. Group 5 holds the multiply-accumulate register. Group 9 holds the interrupt controller's mask and status.

The registers do not all write the same way. Most group-0 registers take the written value as it is. The accumulator is written one 32-bit half at a time. The interrupt mask can only gain bits, and interrupt status bits are cleared by writing ones. Every address that is not mapped, and every read made while the read strobe is low, returns the destination-register value the core supplies. An unmapped read therefore leaves the destination register unchanged. A write to the supervision register that changes a translation-enable bit or the supervisor bit raises a one-cycle flush pulse for the MMU.

Because the access is a single-cycle register instruction, the pins are plain strobes, not a valid/ready pair. The block never stalls an access, so it has no back-pressure rule.

Top module: `spr_access_unit`

## Requirements
- R1: After reset, the supervision register reads 0x00000001 (supervisor bit 0 set), the version register reads the VERSION_RST parameter, and all of these read 0: the vector base, exception PC, effective address, exception status, both accumulator halves, interrupt mask, interrupt status and every shadow register. `mmu_flush` is low after reset.
- R2: The register number is (group << 11) + index. The group-0 indices are: version 0, unit-present 1, CPU config 2, vector base 11, supervision 17, exception PC 32, effective address 48, exception status 64, core ID 128, core count 129. The accumulator indices in group 5 are low half 1 and high half 2. The interrupt indices in group 9 are mask 0 and status 2. A read with `spr_re` high returns the addressed register in the same cycle, with no clock edge needed.
- R3: Core ID always reads 0 and core count always reads 1. Unit-present and CPU-config read their parameter values. Writes to these four addresses change nothing.
- R4: A write with `spr_we` high to version, vector base, supervision, exception PC, effective address or exception status stores the full 32-bit data at the rising edge, and a later read returns it.
- R5: Shadow register r of set s sits at group 0, index 1024 + 32*s + r, for s below NUM_SETS. Each shadow register stores independently of the others.
- R6: A write to the low or high accumulator half replaces only that 32-bit half. The other half keeps its value.
- R7: A write to the interrupt mask ORs the data into it, so a mask bit once set stays set.
- R8: A write to interrupt status clears each status bit that is 1 in the data. Bits written as 0 keep their value.
- R9: Each 1 bit on `irq_set` sets the matching status bit at the rising edge. If a set and a software clear hit the same bit in the same cycle, the bit ends up set.
- R10: A read of an unmapped address returns `spr_rd_old`. Unmapped addresses include indices 16 and 18 of group 0 and all of group 10. A write to an unmapped address changes no register.
- R11: `mmu_flush` is high for exactly the one cycle after a supervision-register write that changes bit 0, 5 or 6. A write that changes only other bits, or changes nothing, leaves it low.
- R12: While `spr_re` is low, `spr_rdata` equals `spr_rd_old`, whatever the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spr_addr | input | 16 | Register number: group in 15:11, index in 10:0 |
| spr_wdata | input | 32 | Write data |
| spr_we | input | 1 | Write strobe, takes effect at the rising edge |
| spr_re | input | 1 | Read strobe |
| spr_rd_old | input | 32 | Current destination-register value, returned for unmapped or idle reads |
| spr_rdata | output | 32 | Read data, combinational from the address |
| irq_set | input | 32 | Per-bit interrupt status set requests |
| mmu_flush | output | 1 | One-cycle pulse after a protection-relevant supervision change |

## Verification
Almost all state is visible only through the combinational read port. A corrupted register therefore shows on `spr_rdata` in the same cycle that its address is read. It does not show earlier, so every write in the vector table is followed by a read of the same register and of its neighbours. Errors specific to one register kind show up as follows. A write to the accumulator that disturbs the wrong half appears on the next read of the untouched half. If the OR-only rule or the write-one-clear rule breaks, a mask or status bit flips at the edge after the write. A wrong comparison behind the flush pulse shows on `mmu_flush` one cycle after the supervision write, or as a pulse that stays high for two cycles.

// File: rtl/spr_pkg.sv
package spr_pkg;
  localparam int GRP_W  = 5;
  localparam int IDX_W  = 11;
  localparam int ADDR_W = GRP_W + IDX_W;
  localparam int DATA_W = 32;
  localparam int SHADOW_REGS = 32;

  localparam logic [GRP_W-1:0] GRP_SYS = 5'd0;
  localparam logic [GRP_W-1:0] GRP_MAC = 5'd5;
  localparam logic [GRP_W-1:0] GRP_PIC = 5'd9;

  localparam logic [IDX_W-1:0] IX_VER     = 11'd0;
  localparam logic [IDX_W-1:0] IX_UPR     = 11'd1;
  localparam logic [IDX_W-1:0] IX_CFG     = 11'd2;
  localparam logic [IDX_W-1:0] IX_VBASE   = 11'd11;
  localparam logic [IDX_W-1:0] IX_SUPV    = 11'd17;
  localparam logic [IDX_W-1:0] IX_EPC     = 11'd32;
  localparam logic [IDX_W-1:0] IX_EADDR   = 11'd48;
  localparam logic [IDX_W-1:0] IX_ESTAT   = 11'd64;
  localparam logic [IDX_W-1:0] IX_COREID  = 11'd128;
  localparam logic [IDX_W-1:0] IX_NCORES  = 11'd129;
  localparam logic [IDX_W-1:0] IX_SHADOW  = 11'd1024;
  localparam logic [IDX_W-1:0] IX_ACC_LO  = 11'd1;
  localparam logic [IDX_W-1:0] IX_ACC_HI  = 11'd2;
  localparam logic [IDX_W-1:0] IX_IRQMASK = 11'd0;
  localparam logic [IDX_W-1:0] IX_IRQSTAT = 11'd2;

  // supervision register: supervisor bit 0, data MMU 5, instruction MMU 6
  localparam int SUPV_SM  = 0;
  localparam int SUPV_DMU = 5;
  localparam int SUPV_IMU = 6;
  localparam logic [DATA_W-1:0] SUPV_FLUSH_BITS =
    (32'd1 << SUPV_SM) | (32'd1 << SUPV_DMU) | (32'd1 << SUPV_IMU);
  localparam logic [DATA_W-1:0] SUPV_RESET = 32'd1 << SUPV_SM;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_VER, SEL_UPR, SEL_CFG, SEL_VBASE, SEL_SUPV,
    SEL_EPC, SEL_EADDR, SEL_ESTAT, SEL_COREID, SEL_NCORES,
    SEL_SHADOW, SEL_ACC_LO, SEL_ACC_HI, SEL_IRQMASK, SEL_IRQSTAT
  } spr_sel_e;
endpackage

// File: rtl/spr_addr_decode.sv
module spr_addr_decode
  import spr_pkg::*;
#(
  parameter int NUM_SETS = 2,
  localparam int SH_DEPTH = NUM_SETS * SHADOW_REGS,
  localparam int SH_AW = $clog2(SH_DEPTH)
) (
  input  logic [ADDR_W-1:0] addr,
  output spr_sel_e          sel,
  output logic [SH_AW-1:0]  shadow_idx
);
  logic [GRP_W-1:0] grp;
  logic [IDX_W-1:0] idx;
  localparam logic [IDX_W:0] SH_LIMIT = IDX_W'(IX_SHADOW) + (IDX_W+1)'(SH_DEPTH);

  assign grp = addr[ADDR_W-1:IDX_W];
  assign idx = addr[IDX_W-1:0];
  // shadow base is bit 10 alone, so the offset is the low index bits
  assign shadow_idx = idx[SH_AW-1:0];

  always_comb begin
    sel = SEL_NONE;
    unique case (grp)
      GRP_SYS: begin
        if (idx >= IX_SHADOW && {1'b0, idx} < SH_LIMIT) sel = SEL_SHADOW;
        else begin
          case (idx)
            IX_VER:    sel = SEL_VER;
            IX_UPR:    sel = SEL_UPR;
            IX_CFG:    sel = SEL_CFG;
            IX_VBASE:  sel = SEL_VBASE;
            IX_SUPV:   sel = SEL_SUPV;
            IX_EPC:    sel = SEL_EPC;
            IX_EADDR:  sel = SEL_EADDR;
            IX_ESTAT:  sel = SEL_ESTAT;
            IX_COREID: sel = SEL_COREID;
            IX_NCORES: sel = SEL_NCORES;
            default:   sel = SEL_NONE;
          endcase
        end
      end
      GRP_MAC: begin
        if (idx == IX_ACC_LO) sel = SEL_ACC_LO;
        else if (idx == IX_ACC_HI) sel = SEL_ACC_HI;
      end
      GRP_PIC: begin
        if (idx == IX_IRQMASK) sel = SEL_IRQMASK;
        else if (idx == IX_IRQSTAT) sel = SEL_IRQSTAT;
      end
      default: sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/spr_shadow_bank.sv
module spr_shadow_bank
  import spr_pkg::*;
#(
  parameter int NUM_SETS = 2,
  localparam int DEPTH = NUM_SETS * SHADOW_REGS,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (we) begin
      regs[idx] <= wdata;
    end
  end

  assign rdata = regs[idx];

  // R5: a stored word is found at the index it was written to
  assert_shadow_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> regs[$past(idx)] == $past(wdata));
endmodule

// File: rtl/spr_irq_regs.sv
module spr_irq_regs
  import spr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_mask,
  input  logic              wr_status,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] irq_set,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] status_q
);
  logic [DATA_W-1:0] clr_bits;

  assign clr_bits = wr_status ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q   <= '0;
      status_q <= '0;
    end else begin
      if (wr_mask) mask_q <= mask_q | wdata;
      status_q <= (status_q & ~clr_bits) | irq_set;
    end
  end

  // R7: the mask never loses a bit
  assert_mask_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($past(mask_q) & ~mask_q) == '0);
  // R8: without a status write no status bit falls
  assert_status_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_status |=> ($past(status_q) & ~status_q) == '0);
  // R9: requested set bits are present after the edge, even under a clear
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set != '0 |=> (status_q & $past(irq_set)) == $past(irq_set));
endmodule

// File: rtl/spr_access_unit.sv
module spr_access_unit
  import spr_pkg::*;
#(
  parameter int NUM_SETS = 2,
  parameter logic [31:0] VERSION_RST  = 32'h1200_0001,
  parameter logic [31:0] UNIT_PRESENT = 32'h0000_0605,
  parameter logic [31:0] CPU_CONFIG   = 32'h0000_0020,
  localparam int SH_AW = $clog2(NUM_SETS * SHADOW_REGS)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] spr_addr,
  input  logic [31:0] spr_wdata,
  input  logic        spr_we,
  input  logic        spr_re,
  input  logic [31:0] spr_rd_old,
  output logic [31:0] spr_rdata,
  input  logic [31:0] irq_set,
  output logic        mmu_flush
);
  spr_sel_e          sel;
  logic [SH_AW-1:0]  sh_idx;
  logic [DATA_W-1:0] sh_rdata, irq_mask, irq_status;
  logic [DATA_W-1:0] ver_q, vbase_q, supv_q, epc_q, eaddr_q, estat_q;
  logic [2*DATA_W-1:0] acc_q;
  logic              supv_wr, supv_changes;

  spr_addr_decode #(.NUM_SETS(NUM_SETS)) u_dec (
    .addr(spr_addr), .sel(sel), .shadow_idx(sh_idx));

  spr_shadow_bank #(.NUM_SETS(NUM_SETS)) u_shadow (
    .clk(clk), .rst_n(rst_n), .we(spr_we && sel == SEL_SHADOW),
    .idx(sh_idx), .wdata(spr_wdata), .rdata(sh_rdata));

  spr_irq_regs u_irq (
    .clk(clk), .rst_n(rst_n),
    .wr_mask(spr_we && sel == SEL_IRQMASK),
    .wr_status(spr_we && sel == SEL_IRQSTAT),
    .wdata(spr_wdata), .irq_set(irq_set),
    .mask_q(irq_mask), .status_q(irq_status));

  assign supv_wr      = spr_we && sel == SEL_SUPV;
  assign supv_changes = ((spr_wdata ^ supv_q) & SUPV_FLUSH_BITS) != '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ver_q     <= VERSION_RST;
      vbase_q   <= '0;
      supv_q    <= SUPV_RESET;
      epc_q     <= '0;
      eaddr_q   <= '0;
      estat_q   <= '0;
      acc_q     <= '0;
      mmu_flush <= 1'b0;
    end else begin
      mmu_flush <= supv_wr && supv_changes;
      if (spr_we) begin
        case (sel)
          SEL_VER:    ver_q   <= spr_wdata;
          SEL_VBASE:  vbase_q <= spr_wdata;
          SEL_SUPV:   supv_q  <= spr_wdata;
          SEL_EPC:    epc_q   <= spr_wdata;
          SEL_EADDR:  eaddr_q <= spr_wdata;
          SEL_ESTAT:  estat_q <= spr_wdata;
          SEL_ACC_LO: acc_q[DATA_W-1:0] <= spr_wdata;
          SEL_ACC_HI: acc_q[2*DATA_W-1:DATA_W] <= spr_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    spr_rdata = spr_rd_old;
    if (spr_re) begin
      case (sel)
        SEL_VER:     spr_rdata = ver_q;
        SEL_UPR:     spr_rdata = UNIT_PRESENT;
        SEL_CFG:     spr_rdata = CPU_CONFIG;
        SEL_VBASE:   spr_rdata = vbase_q;
        SEL_SUPV:    spr_rdata = supv_q;
        SEL_EPC:     spr_rdata = epc_q;
        SEL_EADDR:   spr_rdata = eaddr_q;
        SEL_ESTAT:   spr_rdata = estat_q;
        SEL_COREID:  spr_rdata = '0;
        SEL_NCORES:  spr_rdata = 32'd1;
        SEL_SHADOW:  spr_rdata = sh_rdata;
        SEL_ACC_LO:  spr_rdata = acc_q[DATA_W-1:0];
        SEL_ACC_HI:  spr_rdata = acc_q[2*DATA_W-1:DATA_W];
        SEL_IRQMASK: spr_rdata = irq_mask;
        SEL_IRQSTAT: spr_rdata = irq_status;
        default:     spr_rdata = spr_rd_old;
      endcase
    end
  end

  // R11: a flush pulse always follows a change of a protection bit
  assert_flush_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mmu_flush |-> (($past(supv_q) ^ supv_q) & SUPV_FLUSH_BITS) != '0);
  assert_flush_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (supv_wr && supv_changes) |=> mmu_flush);
  // R6: a low-half write leaves the high half alone
  assert_acc_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (spr_we && sel == SEL_ACC_LO) |=>
      acc_q[2*DATA_W-1:DATA_W] == $past(acc_q[2*DATA_W-1:DATA_W]));
  // R3: core identity reads as zero
  assert_core_id_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (spr_re && sel == SEL_COREID) |-> spr_rdata == '0);
  // R10: unmapped reads pass the old destination through
  assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (spr_re && sel == SEL_NONE) |-> spr_rdata == spr_rd_old);
endmodule

// File: tb/spr_access_unit_test.sv
module spr_access_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] spr_addr;
  logic [31:0] spr_wdata, spr_rd_old, spr_rdata, irq_set;
  logic        spr_we, spr_re, mmu_flush;
  int          n_checks = 0;
  int          n_fail = 0;

  always #5 clk = ~clk;

  spr_access_unit #(.NUM_SETS(2), .VERSION_RST(32'h1200_0001),
    .UNIT_PRESENT(32'h0000_0605), .CPU_CONFIG(32'h0000_0020)) uut (
    .clk(clk), .rst_n(rst_n), .spr_addr(spr_addr), .spr_wdata(spr_wdata),
    .spr_we(spr_we), .spr_re(spr_re), .spr_rd_old(spr_rd_old),
    .spr_rdata(spr_rdata), .irq_set(irq_set), .mmu_flush(mmu_flush));

  typedef struct packed {
    logic        we;
    logic        re;
    logic        chk;
    logic [15:0] addr;
    logic [31:0] wdata;
    logic [31:0] old;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 30;
  // addresses: group 0 base 0x0000, group 5 base 0x2800, group 9 base 0x4800
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,1'b1,16'h0000,32'h0,32'h9,32'h1200_0001,8'd1},  // R1 version
    '{1'b0,1'b1,1'b1,16'h0011,32'h0,32'h9,32'h0000_0001,8'd1},  // R1 supervision
    '{1'b0,1'b1,1'b1,16'h2802,32'h0,32'h9,32'h0,8'd1},          // R1 acc high
    '{1'b1,1'b0,1'b0,16'h000B,32'hDEAD_0100,32'h0,32'h0,8'd4},
    '{1'b0,1'b1,1'b1,16'h000B,32'h0,32'h9,32'hDEAD_0100,8'd4},  // R4
    '{1'b1,1'b0,1'b0,16'h0040,32'h5A5A_0000,32'h0,32'h0,8'd4},
    '{1'b1,1'b0,1'b0,16'h0020,32'h0000_4444,32'h0,32'h0,8'd4},
    '{1'b0,1'b1,1'b1,16'h0040,32'h0,32'h9,32'h5A5A_0000,8'd4},  // R4
    '{1'b0,1'b1,1'b1,16'h0020,32'h0,32'h9,32'h0000_4444,8'd2},  // R2 decode
    '{1'b1,1'b0,1'b0,16'h0080,32'h55,32'h0,32'h0,8'd3},
    '{1'b1,1'b0,1'b0,16'h0081,32'h55,32'h0,32'h0,8'd3},
    '{1'b0,1'b1,1'b1,16'h0080,32'h0,32'h9,32'h0,8'd3},          // R3 core id
    '{1'b0,1'b1,1'b1,16'h0081,32'h0,32'h9,32'h1,8'd3},          // R3 count
    '{1'b0,1'b1,1'b1,16'h0001,32'h0,32'h9,32'h0000_0605,8'd3},  // R3
    '{1'b1,1'b0,1'b0,16'h2801,32'h1111_2222,32'h0,32'h0,8'd6},
    '{1'b1,1'b0,1'b0,16'h2802,32'h3333_4444,32'h0,32'h0,8'd6},
    '{1'b1,1'b0,1'b0,16'h2801,32'h5555_6666,32'h0,32'h0,8'd6},
    '{1'b0,1'b1,1'b1,16'h2802,32'h0,32'h9,32'h3333_4444,8'd6},  // R6
    '{1'b0,1'b1,1'b1,16'h2801,32'h0,32'h9,32'h5555_6666,8'd6},  // R6
    '{1'b1,1'b0,1'b0,16'h4800,32'h0000_000F,32'h0,32'h0,8'd7},
    '{1'b1,1'b0,1'b0,16'h4800,32'h0000_0030,32'h0,32'h0,8'd7},
    '{1'b1,1'b0,1'b0,16'h4800,32'h0000_0000,32'h0,32'h0,8'd7},
    '{1'b0,1'b1,1'b1,16'h4800,32'h0,32'h9,32'h0000_003F,8'd7},  // R7
    '{1'b1,1'b0,1'b0,16'h0405,32'h0000_00A5,32'h0,32'h0,8'd5},
    '{1'b1,1'b0,1'b0,16'h0425,32'h0000_00B6,32'h0,32'h0,8'd5},
    '{1'b0,1'b1,1'b1,16'h0405,32'h0,32'h9,32'h0000_00A5,8'd5},  // R5 set 0
    '{1'b0,1'b1,1'b1,16'h0425,32'h0,32'h9,32'h0000_00B6,8'd5},  // R5 set 1
    '{1'b1,1'b0,1'b0,16'h0010,32'hFFFF_FFFF,32'h0,32'h0,8'd10},
    '{1'b0,1'b1,1'b1,16'h5000,32'h0,32'hCAFE_BABE,32'hCAFE_BABE,8'd10}, // R10
    '{1'b0,1'b0,1'b1,16'h000B,32'h0,32'h0000_0077,32'h0000_0077,8'd12}  // R12
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    spr_we = 1'b0; spr_re = 1'b0; spr_addr = '0; spr_wdata = '0;
    spr_rd_old = '0; irq_set = '0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] old,
                    input logic [31:0] exp, input string req);
    spr_we = 1'b0; spr_re = 1'b1; spr_addr = a; spr_rd_old = old;
    #1 check(req, spr_rdata, exp);
    @(negedge clk); idle();
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    spr_we = 1'b1; spr_re = 1'b0; spr_addr = a; spr_wdata = d;
    @(negedge clk); idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R0 actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 flush", {31'd0, mmu_flush}, 32'd0);
    rd(16'h4802, 32'h9, 32'h0, "R1 irq status");
    rd(16'h0430, 32'h9, 32'h0, "R1 shadow");

    for (int i = 0; i < NV; i++) begin
      spr_we = VECS[i].we; spr_re = VECS[i].re; spr_addr = VECS[i].addr;
      spr_wdata = VECS[i].wdata; spr_rd_old = VECS[i].old;
      #1;
      if (VECS[i].chk) begin
        n_checks++;
        if (spr_rdata !== VECS[i].exp) begin
          n_fail++;
          $display("FAIL R%0d vector %0d actual=%h expected=%h",
                   VECS[i].req, i, spr_rdata, VECS[i].exp);
        end
      end
      @(negedge clk);
    end
    idle();

    // R10: the unmapped write left neighbours intact
    rd(16'h000B, 32'h9, 32'hDEAD_0100, "R10 neighbour");
    rd(16'h0010, 32'h1234_5678, 32'h1234_5678, "R10 index16");
    // R9 set from irq_set
    irq_set = 32'h0000_00F0; @(negedge clk); idle();
    rd(16'h4802, 32'h9, 32'h0000_00F0, "R9 set");
    // R8 write-one-clear
    wr(16'h4802, 32'h0000_0030);
    rd(16'h4802, 32'h9, 32'h0000_00C0, "R8 clear");
    // R9 set wins over clear on the same bit
    spr_we = 1'b1; spr_addr = 16'h4802; spr_wdata = 32'h0000_00C0; irq_set = 32'h0000_0040;
    @(negedge clk); idle();
    rd(16'h4802, 32'h9, 32'h0000_0040, "R9 collision");
    // R11 flush pulse
    wr(16'h0011, 32'h0000_0001);
    check("R11 no change", {31'd0, mmu_flush}, 32'd0);
    wr(16'h0011, 32'h0000_0021);
    check("R11 pulse", {31'd0, mmu_flush}, 32'd1);
    @(negedge clk);
    check("R11 one cycle", {31'd0, mmu_flush}, 32'd0);
    wr(16'h0011, 32'h0000_0029);
    check("R11 other bit", {31'd0, mmu_flush}, 32'd0);
    wr(16'h0011, 32'h0000_0028);
    check("R11 supervisor", {31'd0, mmu_flush}, 32'd1);
    rd(16'h0011, 32'h9, 32'h0000_0028, "R4 supervision");
    // R3 config read, R2 group isolation: group 9 index 1 is unmapped
    rd(16'h0002, 32'h9, 32'h0000_0020, "R3 config");
    rd(16'h4801, 32'h0000_0ABC, 32'h0000_0ABC, "R2 group9 idx1");
    // R5 last shadow slot and first slot beyond the bank
    wr(16'h043F, 32'h0BAD_F00D);
    rd(16'h043F, 32'h9, 32'h0BAD_F00D, "R5 last");
    rd(16'h0440, 32'h0000_0111, 32'h0000_0111, "R10 past bank");

    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule